// File: doc/BRIEF.md
# Cascadable Serial Loader for a Multi-Channel 6-Bit DAC

This block is the digital front end of a multi-channel 6-bit digital-to-analog converter. A host sends a serial bit stream along with a shift clock and an active-low load window signal. While the window is open, each falling edge of the shift clock moves one bit into a chain of 6-bit words, most significant bit first. When the window closes, the whole chain is copied at once into the per-channel code latches. Code 0 selects the lowest analog level and code 63 the highest. The resistor ladder and the analog buffering are outside this block.

The word that arrives last lands on channel 1, the word before it on channel 2, and so on. A short load of N words therefore refreshes channels 1 to N only. The bit that falls off the far end of the chain is driven on a serial output, so several devices can be daisy-chained on one data line. The three host inputs are asynchronous. Each passes through a two-flop synchronizer, and its edges are detected in the fast system clock domain. The channel count is a parameter, four or six.

Top module: `serdac_loader`

## Requirements
- R1: Synchronous active-high reset clears every channel code and the whole shift chain to 0, so the serial output reads 0 after reset.
- R2: A full update shifts NUM_CH words of 6 bits (NUM_CH*6 falling shift-clock edges), each word MSB first. After the commit, channel k (ch_code bits [6k-1:6k-6], k = 1 for bits [5:0]) holds the k-th word counted back from the last one sent.
- R3: A data bit is taken only on a falling edge of the shift clock. The data line may change freely while the shift clock is low or rising.
- R4: While the load window input is high, shift-clock edges do not move the chain, and the serial output holds its value.
- R5: A rising edge of the load window input copies the entire chain into all channel codes in one cycle. At all other times the codes keep their previous values, including during a serial load.
- R6: A load of N < NUM_CH words followed by a commit sets channels 1..N to the new words. Channel N+j receives the word that sat in channel j of the chain before the load.
- R7: The serial output is the most significant chain bit. It changes only on accepted shifts, so the stream leaving the block equals the stream entering it delayed by NUM_CH*6 shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; much faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous serial shift clock; data is taken on its falling edge |
| sdata_in | input | 1 | Asynchronous serial data, MSB of each word first |
| load_n_in | input | 1 | Asynchronous active-low load window; its rising edge commits |
| ser_out | output | 1 | Bit leaving the far end of the chain, for cascading |
| ch_code | output | NUM_CH*6 | Latched codes; bits [6k-1:6k-6] belong to channel k |

## Verification
Full loads are run with all-zero, all-ones, ascending, alternating and irregular code sets. Together they catch reversed word order, reversed bit order and stuck or swapped channels. The serial output is compared bit by bit against the previously loaded pattern as it is pushed out, which fixes the chain length and the cascade delay. Toggling the data line during the shift clock's low and rising phases separates the falling-edge capture from sampling on any other edge. A two-word partial load shows that the chain continues past the refreshed channels. Clocking with the window closed, followed by an empty commit, shows that the chain was left untouched.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int CODE_BITS = 6;

  typedef struct packed {
    logic level;
    logic rose;
    logic fell;
  } sync_sig_t;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync
  import serdac_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  output sync_sig_t q
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {(STAGES+1){RST_VAL}};
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  always_comb begin
    q.level = pipe[STAGES-1];
    q.rose  = pipe[STAGES-1] & ~pipe[STAGES];
    q.fell  = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/serdac_chain.sv
module serdac_chain #(
  parameter int TOT_BITS = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [TOT_BITS-1:0] chain
);
  always_ff @(posedge clk) begin
    if (rst)           chain <= '0;
    else if (shift_en) chain <= {chain[TOT_BITS-2:0], bit_in};
  end
endmodule

// File: rtl/serdac_latch.sv
module serdac_latch #(
  parameter int NUM_CH = 6,
  parameter int CODE_W = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           commit,
  input  logic [NUM_CH*CODE_W-1:0]       chain,
  output logic [NUM_CH-1:0][CODE_W-1:0]  codes
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)         codes[c] <= '0;
      else if (commit) codes[c] <= chain[c*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/serdac_loader.sv
module serdac_loader
  import serdac_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int CODE_W      = CODE_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sclk_in,
  input  logic                        sdata_in,
  input  logic                        load_n_in,
  output logic                        ser_out,
  output logic [NUM_CH*CODE_W-1:0]    ch_code
);
  localparam int TOT_BITS = NUM_CH * CODE_W;

  sync_sig_t sclk_s, sdata_s, load_s;
  logic shift_en, commit;
  logic [TOT_BITS-1:0] chain;
  logic [NUM_CH-1:0][CODE_W-1:0] codes;

  serdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk (
    .clk(clk), .rst(rst), .din(sclk_in), .q(sclk_s));
  serdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdata (
    .clk(clk), .rst(rst), .din(sdata_in), .q(sdata_s));
  serdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_load (
    .clk(clk), .rst(rst), .din(load_n_in), .q(load_s));

  // accept a bit only on a falling shift edge inside an open window
  assign shift_en = sclk_s.fell & ~load_s.level;
  assign commit   = load_s.rose;

  serdac_chain #(.TOT_BITS(TOT_BITS)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en),
    .bit_in(sdata_s.level), .chain(chain));

  serdac_latch #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst(rst), .commit(commit), .chain(chain), .codes(codes));

  assign ser_out = chain[TOT_BITS-1];
  assign ch_code = codes;
endmodule

// File: rtl/serdac_loader_chk.sv
module serdac_loader_chk #(
  parameter int NUM_CH = 6,
  parameter int CODE_W = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       shift_en,
  input logic                       commit,
  input logic                       data_bit,
  input logic                       win_closed,
  input logic [NUM_CH*CODE_W-1:0]   chain,
  input logic                       ser_out,
  input logic [NUM_CH*CODE_W-1:0]   ch_code
);
  localparam int TOT = NUM_CH * CODE_W;
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_CLEAR: assert (ch_code == '0 && ser_out == 1'b0); // R1
    end
  end

  AST_NEW_BIT_IN: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain[0] == $past(data_bit)); // R3

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain[TOT-1:1] == $past(chain[TOT-2:0])); // R2

  AST_WINDOW_GATE: assert property (@(posedge clk) disable iff (rst)
    win_closed |=> $stable(ser_out) && $stable(chain)); // R4

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (rst)
    commit |=> ch_code == $past(chain)); // R5

  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(ch_code)); // R5

  AST_SER_FAR_END: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ser_out == $past(chain[TOT-2])); // R7
endmodule

bind serdac_loader serdac_loader_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .commit(commit),
  .data_bit(sdata_s.level), .win_closed(load_s.level), .chain(chain),
  .ser_out(ser_out), .ch_code(ch_code));

// File: tb/sim_serdac_loader.sv
module sim_serdac_loader;
  localparam int NCH = 6;
  localparam int CW  = 6;
  localparam int TOT = NCH * CW;
  localparam int PH  = 4;
  localparam int NVEC = 5;
  localparam logic [TOT-1:0] VEC [NVEC] = '{
    36'h0,
    36'hFFFFFFFFF,
    {6'd6, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1},
    {6'h15, 6'h2A, 6'h15, 6'h2A, 6'h15, 6'h2A},
    36'h9A3C5E71B
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_in = 1'b1;
  logic sdata_in = 1'b0;
  logic load_n_in = 1'b1;
  logic ser_out;
  logic [TOT-1:0] ch_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serdac_loader #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .load_n_in(load_n_in), .ser_out(ser_out), .ch_code(ch_code));

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // data set while clock high, taken on fall, then disturbed (R3)
  task automatic send_bit(input logic b);
    sdata_in = b;  wait_clks(PH);
    sclk_in = 1'b0; wait_clks(PH);
    sdata_in = ~b; wait_clks(PH);
    sclk_in = 1'b1; wait_clks(PH);
  endtask

  task automatic send_word(input logic [CW-1:0] w);
    for (int i = CW - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic open_win();
    load_n_in = 1'b0; wait_clks(PH);
  endtask

  task automatic close_win();
    load_n_in = 1'b1; wait_clks(2 * PH);
  endtask

  logic [TOT-1:0] prev, held;
  logic [CW-1:0] wx, wy;
  bit ser_ok;
  logic held_ser;

  initial begin
    wait_clks(5);
    rst = 1'b0;
    wait_clks(2);
    check(ch_code == '0 && ser_out == 1'b0, "R1 reset state", ch_code, '0);

    prev = '0;
    for (int v = 0; v < NVEC; v++) begin
      ser_ok = 1'b1;
      open_win();
      for (int c = NCH - 1; c >= 0; c--) begin
        for (int i = CW - 1; i >= 0; i--) begin
          send_bit(VEC[v][c*CW + i]);
          // after j shifts the far end shows prev bit TOT-1-j, or new data
          if (c*CW + i > 0) begin
            if (ser_out !== prev[c*CW + i - 1]) ser_ok = 1'b0;
          end else if (ser_out !== VEC[v][TOT-1]) ser_ok = 1'b0;
        end
        if (c == NCH / 2)
          check(ch_code == prev, "R5 codes hold mid-load", ch_code, prev);
      end
      check(ser_ok, "R7 serial output stream", {35'd0, ser_out}, prev);
      close_win();
      check(ch_code == VEC[v], "R2 full load word order", ch_code, VEC[v]);
      prev = VEC[v];
    end

    // R4: clocking with the window closed moves nothing
    held_ser = ser_out;
    for (int i = 0; i < 8; i++) send_bit(~held_ser);
    check(ser_out == held_ser, "R4 ser_out holds with window closed",
          {35'd0, ser_out}, {35'd0, held_ser});
    held = ch_code;
    open_win();
    close_win();
    check(ch_code == prev, "R4 chain untouched, empty commit", ch_code, prev);
    check(ch_code == held, "R5 empty commit copies same chain", ch_code, held);

    // R6: partial load of two words
    wx = 6'h3F; wy = 6'h21;
    open_win();
    send_word(wx);
    send_word(wy);
    close_win();
    check(ch_code == {prev[TOT-1-2*CW:0], wx, wy}, "R6 partial load",
          ch_code, {prev[TOT-1-2*CW:0], wx, wy});

    // R6: single word on ch1, rest moves up one slot
    held = ch_code;
    open_win();
    send_word(6'h07);
    close_win();
    check(ch_code == {held[TOT-1-CW:0], 6'h07}, "R6 single word load",
          ch_code, {held[TOT-1-CW:0], 6'h07});

    // R1: reset in mid-operation
    rst = 1'b1; wait_clks(2);
    rst = 1'b0; wait_clks(2);
    check(ch_code == '0 && ser_out == 1'b0, "R1 reset after use", ch_code, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule